// File: doc/BRIEF.md
# SPI Flash Command Framer

This block sits behind the mode-0 serial interface of a flash device and turns the raw chip-select, serial clock and data-in lines into framed commands. The three serial lines are brought into the system clock domain through two-flop synchronizers. Bits are taken on each rising serial clock edge while chip select is low, and they are assembled most significant bit first. The first complete byte of a frame is the opcode. The bytes that follow it (address, data or dummy bytes) are only counted.

When chip select rises, the block decides whether the frame is kept or thrown away. Read-class commands may stop after any bit. Write-class commands, which cover write, program, erase and status-write operations, are kept only when they end on a whole byte. While the program/erase engine raises `busy`, only the read-status command can pass. A kept frame produces a one-cycle `cmd_valid` pulse with the opcode and the number of complete bytes, and a downstream executor acts on it.

Top module: `spi_cmd_framer`

## Requirements
- R1: Serial data is sampled on the rising edge of `spi_sck` while `spi_cs_n` is low, MSB first. The first eight bits of a frame form the opcode reported on `cmd_opcode`.
- R2: A frame that is kept produces exactly one `cmd_valid` pulse of one clock cycle, after chip select rises. The pulse carries the opcode and the count of complete bytes received, opcode included. Both outputs hold their values between pulses.
- R3: Read-class opcodes are kept when chip select rises after any number of bits at or beyond the opcode. A trailing partial byte is not counted. The read-class opcodes are 0x03, 0x0B, 0x05, 0x9F and 0x3B.
- R4: Write-class opcodes are kept only when the total bit count is a multiple of 8, and are otherwise discarded. The write-class opcodes are 0x06, 0x04, 0x01, 0x02, 0x20, 0xD8, 0xC7 and 0x60.
- R5: While `busy` is high at the end of a frame, only the read-status opcode 0x05 is kept. Every other frame is discarded.
- R6: Opcodes in neither class are discarded.
- R7: A frame that ends before eight bits have been clocked produces no pulse.
- R8: The bit and byte counters are cleared while chip select is high. Serial clock edges seen with chip select high have no effect on the next frame.
- R9: After reset, `cmd_valid` is low and `cmd_opcode` and `cmd_bytes` are zero.
- R10: The byte count saturates at 2**CNT_W-1 (255 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| busy | input | 1 | Program/erase/status-write cycle in progress |
| cmd_valid | output | 1 | One-cycle pulse for a kept command |
| cmd_opcode | output | 8 | Opcode of the last kept command |
| cmd_bytes | output | CNT_W | Complete bytes in the last kept command |

## Verification
The assertions take several things for granted about the inputs:
- The serial clock is slow compared with the system clock, so that every serial level lasts several system cycles.
- Data-in changes only on falling serial clock edges.
- `busy` does not change while a frame is being closed.
- Chip select stays high for several cycles after each frame.

The bench drives the serial clock with a half period of three system cycles and sets data on the falling edge. It holds `busy` fixed for each whole frame and waits twenty cycles with chip select high before it checks the outputs. The sweep covers every opcode class, both `busy` levels, several byte counts and every trailing partial-bit count.

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer #(
  parameter int          CNT_W   = 8,
  parameter logic [7:0]  OP_RDSR = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             busy,
  output logic             cmd_valid,
  output logic [7:0]       cmd_opcode,
  output logic [CNT_W-1:0] cmd_bytes
);
  localparam logic [CNT_W-1:0] MAXB = {CNT_W{1'b1}};
  localparam logic [1:0] CL_NONE = 2'd0, CL_RD = 2'd1, CL_WR = 2'd2;

  function automatic logic [1:0] op_class(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B, 8'h05, 8'h9F, 8'h3B:                 return CL_RD;
      8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60: return CL_WR;
      default:                                          return CL_NONE;
    endcase
  endfunction

  logic [2:0]       cs_q, sck_q;
  logic [1:0]       mosi_q;
  logic [6:0]       shreg;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       opcode_r;

  wire       sck_rise = sck_q[1] & ~sck_q[2];
  wire       cs_rise  = cs_q[1] & ~cs_q[2];
  wire [1:0] cls      = op_class(opcode_r);
  wire       accept   = (byte_cnt != '0) && (cls != CL_NONE) &&
                        (cls == CL_RD || bit_cnt == 3'd0) &&
                        (!busy || opcode_r == OP_RDSR);
  wire [7:0] next_byte = {shreg, mosi_q[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q       <= 3'b111;
      sck_q      <= '0;
      mosi_q     <= '0;
      shreg      <= '0;
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      opcode_r   <= '0;
      cmd_valid  <= 1'b0;
      cmd_opcode <= '0;
      cmd_bytes  <= '0;
    end else begin
      cs_q      <= {cs_q[1:0], spi_cs_n};
      sck_q     <= {sck_q[1:0], spi_sck};
      mosi_q    <= {mosi_q[0], spi_mosi};
      cmd_valid <= 1'b0;
      if (cs_q[1]) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        if (cs_rise && accept) begin
          cmd_valid  <= 1'b1;
          cmd_opcode <= opcode_r;
          cmd_bytes  <= byte_cnt;
        end
      end else if (sck_rise) begin
        shreg   <= next_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != MAXB) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0)   opcode_r <= next_byte;
        end
      end
    end
  end
endmodule

module spi_cmd_framer_chk #(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] OP_RDSR = 8'h05
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             busy,
  input logic             cmd_valid,
  input logic [7:0]       cmd_opcode,
  input logic [CNT_W-1:0] cmd_bytes
);
  function automatic logic known_op(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B, 8'h05, 8'h9F, 8'h3B,
      8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r2_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(spi_cs_n, 2));
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cmd_opcode) && $stable(cmd_bytes) || cmd_valid);
  a_r5_busy_rdsr_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(busy) |-> cmd_opcode == OP_RDSR);
  a_r6_known_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> known_op(cmd_opcode));
  a_r7_opcode_complete: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bytes != '0);
endmodule

bind spi_cmd_framer spi_cmd_framer_chk #(.CNT_W(CNT_W), .OP_RDSR(OP_RDSR)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_bytes(cmd_bytes));

// File: tb/tb_spi_cmd_framer.sv
`timescale 1ns/1ps
module tb_spi_cmd_framer;
  localparam int CNT_W = 8;
  localparam int HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic             cmd_valid;
  logic [7:0]       cmd_opcode;
  logic [CNT_W-1:0] cmd_bytes;

  int tests = 0, fails = 0, pulses = 0;
  logic [7:0] last_op;
  int         last_bytes;

  always #4 clk = ~clk;

  spi_cmd_framer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_bytes(cmd_bytes));

  always @(negedge clk) if (rst_n && cmd_valid) begin
    pulses++;
    last_op    = cmd_opcode;
    last_bytes = int'(cmd_bytes);
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expired (actual hung, expected finish)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int cls(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B, 8'h05, 8'h9F, 8'h3B: return 1;
      8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input int nbits);
    cs_n = 1'b0; clks(HALF);
    for (int j = 0; j < nbits; j++) begin
      int k;
      logic [7:0] b;
      k = j / 8;
      b = (k == 0) ? op : 8'((k * 29 + 7) & 255);
      sck = 1'b0; mosi = b[7 - (j % 8)]; clks(HALF);
      sck = 1'b1; clks(HALF);
    end
    sck = 1'b0; clks(HALF);
    cs_n = 1'b1; clks(20);
  endtask

  task automatic noise();
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; sck = 1'b1; clks(HALF);
      sck = 1'b0; clks(HALF);
    end
  endtask

  task automatic run(input logic [7:0] op, input int nbits, input logic bz, input string tag);
    int  p0, eb;
    logic ok, exp_c;
    busy = bz;
    p0 = pulses;
    frame(op, nbits);
    busy = 1'b0;
    eb = nbits / 8;
    if (eb > 255) eb = 255;
    exp_c = (nbits >= 8) && cls(op) != 0 && (cls(op) == 1 || nbits % 8 == 0) &&
            (!bz || op == 8'h05);
    tests++;
    if (exp_c) ok = (pulses == p0 + 1) && last_op == op && last_bytes == eb;
    else       ok = (pulses == p0);
    if (!ok) begin
      fails++;
      $display("FAIL %s: op=%h bits=%0d busy=%0b actual pulses=%0d op=%h bytes=%0d expected pulses=%0d op=%h bytes=%0d",
               tag, op, nbits, bz, pulses - p0, last_op, last_bytes, exp_c ? 1 : 0, op, eb);
    end
  endtask

  logic [7:0] ops [16] = '{8'h03, 8'h0B, 8'h05, 8'h9F, 8'h3B, 8'h06, 8'h04, 8'h01,
                          8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60, 8'h00, 8'hFF, 8'h5A};

  initial begin
    clks(5);
    tests++;
    if (cmd_valid !== 1'b0 || cmd_opcode !== 8'h00 || cmd_bytes !== '0) begin
      fails++;
      $display("FAIL R9: reset actual v=%b op=%h n=%h expected 0 00 00", cmd_valid, cmd_opcode, cmd_bytes);
    end
    rst_n = 1'b1; clks(5);
    tests++;
    if (cmd_valid !== 1'b0 || cmd_opcode !== 8'h00 || cmd_bytes !== '0) begin
      fails++;
      $display("FAIL R9: after reset actual v=%b op=%h n=%h expected 0 00 00", cmd_valid, cmd_opcode, cmd_bytes);
    end

    for (int o = 0; o < 16; o++)
      for (int bz = 0; bz < 2; bz++)
        for (int nb = 1; nb <= 3; nb += 2)
          for (int xb = 0; xb < 8; xb++) begin
            if (xb == 3) noise();
            run(ops[o], nb * 8 + xb, bz[0], "R1 R2 R3 R4 R5 R6 R8");
          end

    for (int o = 0; o < 16; o++)
      for (int nbits = 0; nbits < 8; nbits++)
        run(ops[o], nbits, 1'b0, "R7");

    noise();
    run(8'h9F, 8, 1'b0, "R8");
    run(8'h03, 300 * 8 + 3, 1'b0, "R10");
    run(8'h02, 260 * 8, 1'b0, "R10");
    run(8'h05, 257 * 8 + 1, 1'b1, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule